// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a nine-bit first-in first-out buffer whose write side and read side run on unrelated clocks. The storage is an inferred dual-port array of `DEPTH` words. A writer pushes words through an active-low primary enable and a secondary pin. The function of the secondary pin is chosen by the level it holds while reset is low. A reader pops words through two active-low enables. The read data comes from an output register that goes to high impedance when the active-low output enable is high.

There are four active-low status outputs: empty, full, almost-empty and almost-full. Empty and almost-empty are registered on the read clock. Full and almost-full are registered on the write clock. The two almost thresholds come from offset inputs that a separate block supplies. That block holds them at 7 until software loads new values. Write and read pointers are one bit wider than the address. They cross to the other domain in Gray code through two-flop synchronizers, so each flag is formed from the local next pointer and a delayed copy of the remote one.

Each domain has its own copy of a small mode state machine. `MODE_RESET` is held while reset is low, and during that time the level of `wr_en2_ld` is sampled. On the first clock after reset it moves to `MODE_DUAL_EN` if the sample was high, or to `MODE_LOAD_CTL` if it was low. Both run states keep their value until the next reset. `MODE_DUAL_EN` treats the pin as a second, active-high write enable. `MODE_LOAD_CTL` treats it as an offset-access control: while it is low, the buffer neither accepts data nor gives it out.

Top module: `dcfifo_pflag`

## Requirements
- R1: A word is stored at a `wr_clk` rising edge only when `wr_en_n` is 0, `wr_en2_ld` is 1 and `full_n` is 1. If `wr_en2_ld` is 0, nothing is stored.
- R2: While `full_n` is 0, no write takes effect whatever the enables are. No stored word is overwritten before it has been read.
- R3: A read takes place at a `rd_clk` rising edge only when `rd_en1_n` and `rd_en2_n` are both 0 and `empty_n` is 1. Words leave in the order they were written.
- R4: While `empty_n` is 0, read requests are ignored and `rd_q` keeps the last word that was actually read.
- R5: When settled, `aempty_n` is 0 exactly when the unread count is at most `ae_off`. It is updated on `rd_clk` edges only.
- R6: When settled, `afull_n` is 0 exactly when the unread count is at least `DEPTH - af_off`. It is updated on `wr_clk` edges only.
- R7: When settled, `empty_n` is 0 exactly at a count of 0 and `full_n` is 0 exactly at a count of `DEPTH`. Each of these flags can fall only after an operation in its own domain.
- R8: Reset empties the buffer. Afterwards `empty_n` and `aempty_n` are 0, `full_n` and `afull_n` are 1, and `rd_q` is 0.
- R9: The mode is fixed by the `wr_en2_ld` level during reset and does not change until the next reset. In load-control mode, data is neither written nor read while `wr_en2_ld` is 0.
- R10: When words are written into an empty buffer while the read enables are held low, the first word appears on `rd_q` at the first `rd_clk` edge at which `empty_n` is already 1, and not earlier.
- R11: While `out_en_n` is 1, `rd_q` is high impedance on all bits. While it is 0, `rd_q` drives the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset for both sides |
| wr_data | input | WIDTH | Word to be written |
| wr_en_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Second write enable or offset-access control, chosen at reset |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| out_en_n | input | 1 | Output drive enable, active low |
| ae_off | input | OFS_W | Almost-empty offset n |
| af_off | input | OFS_W | Almost-full offset m |
| rd_q | output | WIDTH | Read data, tri-stated |
| empty_n | output | 1 | Empty flag, active low, read clock |
| aempty_n | output | 1 | Almost-empty flag, active low, read clock |
| full_n | output | 1 | Full flag, active low, write clock |
| afull_n | output | 1 | Almost-full flag, active low, write clock |

## Verification
The assertions take four things for granted. Reset lasts at least two edges of each clock, so that both mode machines capture the selection. The offsets are below `DEPTH` and change only while the buffer is idle. In load-control mode, `wr_en2_ld` is held steady around read-clock edges, because the read side samples it directly. The stimulus holds reset for several read-clock periods and releases it on a falling write-clock edge. It changes the offsets and toggles `wr_en2_ld` in load-control mode only after both enables have been idle for a settling window. Random traffic toggles `wr_en2_ld` only in dual-enable mode, where the read side ignores it.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;
    // Per-domain operating mode, fixed when reset is released
    typedef enum logic [1:0] {
        MODE_RESET    = 2'd0,
        MODE_DUAL_EN  = 2'd1,
        MODE_LOAD_CTL = 2'd2
    } mode_e;
endpackage

// File: rtl/dcf_mode_fsm.sv
`timescale 1ns/1ps
module dcf_mode_fsm
    import dcfifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sel_level,
    output mode_e mode,
    output logic  run,
    output logic  load_mode
);
    logic  sel_cap;
    mode_e mode_nx;

    // Level of the dual-role pin, sampled only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) sel_cap <= sel_level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode <= MODE_RESET;
        else        mode <= mode_nx;
    end

    always_comb begin
        mode_nx = mode;
        unique case (mode)
            MODE_RESET:    mode_nx = sel_cap ? MODE_DUAL_EN : MODE_LOAD_CTL;
            MODE_DUAL_EN:  mode_nx = MODE_DUAL_EN;
            MODE_LOAD_CTL: mode_nx = MODE_LOAD_CTL;
            default:       mode_nx = MODE_RESET;
        endcase
    end

    always_comb begin
        run       = (mode != MODE_RESET);
        load_mode = (mode == MODE_LOAD_CTL);
    end

    // R9: once a run mode is taken it stays until reset
    a_r9_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_RESET) |=> $stable(mode));
endmodule

// File: rtl/dcf_gray_sync.sv
`timescale 1ns/1ps
module dcf_gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage1, stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    // Gray to binary: each bit is the parity of itself and all higher bits
    always_comb begin
        for (int i = 0; i < W; i++) bin_out[i] = ^(stage2 >> i);
    end
endmodule

// File: rtl/dcf_dpram.sv
`timescale 1ns/1ps
module dcf_dpram #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/dcfifo_pflag.sv
`timescale 1ns/1ps
module dcfifo_pflag
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = 9,
    parameter int OFS_W = $clog2(DEPTH) + 1
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_en_n,
    input  logic             wr_en2_ld,
    input  logic             rd_en1_n,
    input  logic             rd_en2_n,
    input  logic             out_en_n,
    input  logic [OFS_W-1:0] ae_off,
    input  logic [OFS_W-1:0] af_off,
    output wire  [WIDTH-1:0] rd_q,
    output logic             empty_n,
    output logic             aempty_n,
    output logic             full_n,
    output logic             afull_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    mode_e            wmode, rmode;
    logic             wrun, rrun, wload, rload;
    logic             wr_fire, rd_fire;
    logic [PW-1:0]    wbin, wbin_nx, wgray, rbin_w, wcnt_nx;
    logic [PW-1:0]    rbin, rbin_nx, rgray, wbin_r, rcnt_nx;
    logic [WIDTH-1:0] rq;

    dcf_mode_fsm u_wmode (.clk(wr_clk), .rst_n(rst_n), .sel_level(wr_en2_ld),
                          .mode(wmode), .run(wrun), .load_mode(wload));
    dcf_mode_fsm u_rmode (.clk(rd_clk), .rst_n(rst_n), .sel_level(wr_en2_ld),
                          .mode(rmode), .run(rrun), .load_mode(rload));

    dcf_gray_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rbin_w));
    dcf_gray_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wbin_r));

    // ---------------- write domain ----------------
    // Data writes need the pin high in both modes; wload only names the role
    always_comb begin
        wr_fire = wrun && !wr_en_n && wr_en2_ld && full_n;
        wbin_nx = wbin + PW'(wr_fire);
        wcnt_nx = wbin_nx - rbin_w;
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin    <= '0;
            wgray   <= '0;
            full_n  <= 1'b1;
            afull_n <= 1'b1;
        end else begin
            wbin    <= wbin_nx;
            wgray   <= wbin_nx ^ (wbin_nx >> 1);
            full_n  <= (wcnt_nx != DEPTH_P);
            afull_n <= (wcnt_nx < (DEPTH_P - PW'(af_off)));
        end
    end

    // R2: a full buffer does not advance the write pointer
    a_r2_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |=> $stable(wbin));
    // R7: full can only fall after an accepted write
    a_r7_full_after_write: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $fell(full_n) |-> $past(wr_fire));
    // R9: load-control role of the pin is never seen before reset is released
    a_r9_wr_role: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wload |-> wrun);

    // ---------------- read domain ----------------
    always_comb begin
        rd_fire = rrun && (!rload || wr_en2_ld) && !rd_en1_n && !rd_en2_n && empty_n;
        rbin_nx = rbin + PW'(rd_fire);
        rcnt_nx = wbin_r - rbin_nx;
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin     <= '0;
            rgray    <= '0;
            empty_n  <= 1'b0;
            aempty_n <= 1'b0;
        end else begin
            rbin     <= rbin_nx;
            rgray    <= rbin_nx ^ (rbin_nx >> 1);
            empty_n  <= (rcnt_nx != '0);
            aempty_n <= (rcnt_nx > PW'(ae_off));
        end
    end

    // R4: an empty buffer neither moves the read pointer nor changes the output word
    a_r4_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |=> ($stable(rbin) && $stable(rq)));
    // R7: empty can only fall after an accepted read
    a_r7_empty_after_read: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $fell(empty_n) |-> $past(rd_fire));
    // R5: an empty buffer is always almost empty
    a_r5_empty_in_ae: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    dcf_dpram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wclk(wr_clk), .we(wr_fire), .waddr(wbin[AW-1:0]), .wdata(wr_data),
        .rclk(rd_clk), .rst_n(rst_n), .re(rd_fire), .raddr(rbin[AW-1:0]), .rdata(rq));

    // R11: tri-state output driver
    assign rd_q = out_en_n ? {WIDTH{1'bz}} : rq;
endmodule

// File: tb/dcfifo_pflag_test.sv
`timescale 1ns/1ps
module dcfifo_pflag_test;
    localparam int DEPTH = 16;
    localparam int WIDTH = 9;
    localparam int OW    = 5;

    logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic wr_en_n = 1'b1, wr_en2_ld = 1'b1, rd_en1_n = 1'b1, rd_en2_n = 1'b1, out_en_n = 1'b0;
    logic [OW-1:0] ae = 5'd7, af = 5'd7;
    wire  [WIDTH-1:0] rd_q;
    logic empty_n, aempty_n, full_n, afull_n;

    int errs = 0, checks = 0;
    bit done = 0, dual = 1, pend = 0;
    logic [WIDTH-1:0] model[$];
    logic [WIDTH-1:0] exp_word = '0, last_rd = '0;

    dcfifo_pflag #(.DEPTH(DEPTH), .WIDTH(WIDTH), .OFS_W(OW)) uut (
        .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .wr_data(wr_data),
        .wr_en_n(wr_en_n), .wr_en2_ld(wr_en2_ld), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
        .out_en_n(out_en_n), .ae_off(ae), .af_off(af), .rd_q(rd_q),
        .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n));

    always #4   wclk = ~wclk;   // 125 MHz write clock
    always #5.5 rclk = ~rclk;   // unrelated read clock

    task automatic chk(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic bit rd_ok();
        return dual || wr_en2_ld;
    endfunction

    task automatic check_pending();
        if (pend) begin
            chk(rd_q === exp_word, "R3 read order", int'(rd_q), int'(exp_word));
            last_rd = exp_word;
            pend = 0;
        end
    endtask

    task automatic check_flags(string tag);
        int n = model.size();
        chk(empty_n  == (n != 0),              {"R7 empty_n ", tag},  empty_n,  n != 0);
        chk(full_n   == (n != DEPTH),          {"R7 full_n ", tag},   full_n,   n != DEPTH);
        chk(aempty_n == (n > int'(ae)),        {"R5 aempty_n ", tag}, aempty_n, n > int'(ae));
        chk(afull_n  == (n < DEPTH - int'(af)),{"R6 afull_n ", tag},  afull_n,  n < DEPTH - int'(af));
    endtask

    task automatic do_reset(bit lvl);
        @(negedge wclk);
        rst_n = 0; wr_en_n = 1; wr_en2_ld = lvl; rd_en1_n = 1; rd_en2_n = 1;
        repeat (4) @(negedge rclk);
        model.delete(); last_rd = '0; pend = 0; dual = lvl;
        @(negedge wclk);
        rst_n = 1;
    endtask

    task automatic settle();
        wr_en_n = 1; rd_en1_n = 1; rd_en2_n = 1;
        repeat (8) @(negedge rclk);
    endtask

    task automatic push_words(int k);
        repeat (k) begin
            @(negedge wclk);
            wr_data = WIDTH'($urandom); wr_en_n = 0; wr_en2_ld = 1;
            if (full_n) model.push_back(wr_data);
        end
        @(negedge wclk);
        wr_en_n = 1;
    endtask

    task automatic pop_words(int k);
        repeat (k) begin
            @(negedge rclk);
            check_pending();
            rd_en1_n = 0; rd_en2_n = 0;
            if (empty_n && rd_ok()) begin
                if (model.size() == 0) chk(0, "R4 data offered while model empty", 1, 0);
                else begin pend = 1; exp_word = model.pop_front(); end
            end
        end
        @(negedge rclk);
        check_pending();
        rd_en1_n = 1; rd_en2_n = 1;
    endtask

    task automatic rand_phase(int wpct, int rpct, int n);
        fork
            begin
                repeat (n) begin
                    @(negedge wclk);
                    wr_data   = WIDTH'($urandom);
                    wr_en_n   = ($urandom_range(99) >= wpct);
                    wr_en2_ld = ($urandom_range(9) != 0);
                    if (!wr_en_n && wr_en2_ld && full_n) model.push_back(wr_data);
                end
                @(negedge wclk);
                wr_en_n = 1; wr_en2_ld = 1;
            end
            begin
                repeat (n) begin
                    @(negedge rclk);
                    check_pending();
                    rd_en1_n = ($urandom_range(99) >= rpct);
                    rd_en2_n = ($urandom_range(9) == 0);
                    if (!rd_en1_n && !rd_en2_n && empty_n) begin
                        if (model.size() == 0) chk(0, "R4 data offered while model empty", 1, 0);
                        else begin pend = 1; exp_word = model.pop_front(); end
                    end
                end
                @(negedge rclk);
                check_pending();
                rd_en1_n = 1; rd_en2_n = 1;
            end
        join
    endtask

    initial begin
        void'($urandom(32'd2024));
        do_reset(1);
        repeat (3) @(negedge rclk);
        // R8: reset state
        chk(empty_n == 0 && aempty_n == 0, "R8 empty flags low after reset", {empty_n, aempty_n}, 0);
        chk(full_n == 1 && afull_n == 1,   "R8 full flags high after reset", {full_n, afull_n}, 3);
        chk(rd_q === '0, "R8 output zero after reset", int'(rd_q), 0);
        // R11: output enable
        out_en_n = 1; #1;
        chk(rd_q === {WIDTH{1'bz}}, "R11 high impedance when disabled", int'(rd_q), 0);
        out_en_n = 0; #1;
        chk(rd_q === '0, "R11 driven when enabled", int'(rd_q), 0);

        // R1: second enable low blocks writes in dual-enable mode
        @(negedge wclk); wr_en_n = 0; wr_en2_ld = 0;
        repeat (3) @(negedge wclk);
        wr_en_n = 1; wr_en2_ld = 1;
        settle();
        chk(empty_n == 0, "R1 no write with second enable low", empty_n, 0);

        // R10: first word latency
        push_words(1);
        @(negedge rclk); rd_en1_n = 0; rd_en2_n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge rclk);
            if (empty_n) break;
        end
        chk(rd_q === last_rd, "R10 word not shown before empty_n rises", int'(rd_q), int'(last_rd));
        exp_word = model.pop_front();
        @(negedge rclk);
        chk(rd_q === exp_word, "R10 first word one edge after empty_n rises", int'(rd_q), int'(exp_word));
        last_rd = exp_word;
        rd_en1_n = 1; rd_en2_n = 1;
        settle();
        check_flags("after first word");

        // R3: one read enable high blocks reads
        push_words(2);
        settle();
        @(negedge rclk); rd_en1_n = 0; rd_en2_n = 1;
        repeat (5) @(negedge rclk);
        settle();
        chk(rd_q === last_rd, "R3 no read with one enable high", int'(rd_q), int'(last_rd));
        check_flags("two words held");
        pop_words(2);

        // R5 R6: thresholds with default offsets of 7
        settle();
        push_words(7);  settle(); check_flags("7 words offs 7");
        push_words(1);  settle(); check_flags("8 words offs 7");
        push_words(1);  settle(); check_flags("9 words offs 7");
        // new offsets, changed while idle
        ae = 5'd2; af = 5'd3;
        settle();       check_flags("9 words offs 2/3");
        push_words(3);  settle(); check_flags("12 words offs 2/3");
        push_words(1);  settle(); check_flags("13 words offs 2/3");
        // R2: overfill
        push_words(DEPTH);
        settle();
        chk(model.size() == DEPTH, "R2 accepted count stops at depth", model.size(), DEPTH);
        check_flags("full");
        // drain past empty, R4 keeps last word
        pop_words(DEPTH + 3);
        settle();
        check_flags("drained");
        @(negedge rclk); rd_en1_n = 0; rd_en2_n = 0;
        repeat (6) @(negedge rclk);
        chk(rd_q === last_rd, "R4 last word kept while empty", int'(rd_q), int'(last_rd));
        settle();
        push_words(1); settle(); check_flags("1 word offs 2/3");
        push_words(2); settle(); check_flags("3 words offs 2/3");
        pop_words(3);  settle();

        // random traffic
        ae = 5'd7; af = 5'd7;
        settle();
        rand_phase(85, 25, 300); settle(); check_flags("random write-heavy");
        rand_phase(25, 85, 300); settle(); check_flags("random read-heavy");
        rand_phase(60, 60, 400); settle(); check_flags("random balanced");

        // R8: reset in the middle of traffic
        push_words(5);
        do_reset(1);
        repeat (3) @(negedge rclk);
        check_flags("R8 after mid-run reset");
        chk(rd_q === '0, "R8 output cleared by reset", int'(rd_q), 0);

        // R9: load-control mode
        do_reset(0);
        repeat (3) @(negedge rclk);
        @(negedge wclk); wr_en_n = 0;
        repeat (4) @(negedge wclk);
        wr_en_n = 1;
        settle();
        chk(empty_n == 0, "R9 no write while control low", empty_n, 0);
        push_words(3);
        settle();
        check_flags("R9 three words with control high");
        @(negedge wclk); wr_en2_ld = 0;
        settle();
        @(negedge rclk); rd_en1_n = 0; rd_en2_n = 0;
        repeat (6) @(negedge rclk);
        settle();
        chk(rd_q === '0, "R9 no read while control low", int'(rd_q), 0);
        check_flags("R9 words kept while control low");
        @(negedge wclk); wr_en2_ld = 1;
        settle();
        pop_words(3);
        settle();
        check_flags("R9 drained");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wclk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule